// File: doc/BRIEF.md
# Split-or-unified timer state register

This block holds the state variables and the count of an event-driven timer and gives software access to both over a 32-bit register bus. The timer runs either as two independent 16-bit halves (low and high), each with its own 5-bit state variable and its own halt input, or as a single 32-bit counter steered by the low state variable alone. A configuration input selects between the two arrangements. While a half is not halted its counter advances by one per clock.

Event logic outside the block updates the state variables through a per-half event port. Each event carries a 5-bit value and a load flag: the value either replaces the state or is added to it. Software may read the state and the count at any moment. A software write is accepted only while the half it targets is halted. A write that reaches a running half changes nothing in that half and is answered with a one-cycle bus error.

Top module: `tsr_regunit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) both state variables, the whole 32-bit count and bus_err are zero.
- R2: A read with bus_addr = 1 returns the low state in bits 4:0 and the high state in bits 20:16. All other bits read as zero. While unify = 1 the high state field reads as zero.
- R3: In split mode (unify = 0) a state write with byte strobe 0 loads the low state from wdata[4:0] if halt_lo = 1. A write with byte strobe 2 loads the high state from wdata[20:16] if halt_hi = 1. Both can happen in one 32-bit write, and the new value is visible after the clock edge.
- R4: A write is refused for a half if any of that half's strobes (bits 1:0 for low, 3:2 for high) is set while the half is not halted. The refused half keeps its value, and bus_err is high for exactly the one cycle after the write. A permitted half in the same write is still updated.
- R5: While unify = 1, halt_lo governs write permission for all four byte lanes. The high state ignores software writes and high events, and keeps its stored value.
- R6: An event with its load flag set replaces that half's state with the event value.
- R7: An event with its load flag clear adds the event value to that half's state, modulo 32.
- R8: When a permitted software write and an event hit the same half in one cycle, the software value is taken.
- R9: In split mode each 16-bit count half advances by one per clock while its own halt is 0, wraps from 0xFFFF to 0 without affecting the other half, and holds while halted.
- R10: While unify = 1 the 32-bit count advances by one per clock while halt_lo = 0, carrying from bit 15 into bit 16 and wrapping at 2^32.
- R11: A write with bus_addr = 0 replaces each strobed byte of the count, subject to the same halt permission as R4 and R5. A permitted write takes precedence over counting.
- R12: A read with bus_addr = 0 returns the 32-bit count, low half in bits 15:0 and high half in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| unify | input | 1 | 1 = one 32-bit counter, 0 = two 16-bit halves |
| halt_lo | input | 1 | Low half halted (whole counter when unified) |
| halt_hi | input | 1 | High half halted (split mode only) |
| bus_wr | input | 1 | Write request this cycle |
| bus_addr | input | 1 | Register select: 0 = count, 1 = state |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| bus_err | output | 1 | Refused-write response, one cycle after the write |
| ev_lo_vld | input | 1 | Event on the low state |
| ev_lo_load | input | 1 | 1 = load, 0 = add |
| ev_lo_val | input | 5 | Low event value |
| ev_hi_vld | input | 1 | Event on the high state |
| ev_hi_load | input | 1 | 1 = load, 0 = add |
| ev_hi_val | input | 5 | High event value |
| state_lo | output | 5 | Current low state |
| state_hi | output | 5 | Current high state (stored value) |
| count | output | 32 | Current count |

## Verification
The embedded assertions check on every cycle the properties that hold locally:
- a bus error only follows a write;
- software beats an event;
- load and add act on the state;
- a running half without an event holds its state;
- counting steps by one in each mode;
- the reserved read bits stay zero.

Only the bench's sweeps show the following, because each needs a full write-then-observe sequence:
- that every strobe, halt and mode combination yields the right mix of accepted halves, refused halves and error pulse;
- that carries cross or stay at the half boundary as the mode demands;
- that every state and event value pair gives the exact modulo-32 result.

// File: rtl/tsr_pkg.sv
// Package: shared constants and types of the timer state/count register unit.
// Assumes: state width fits in one byte lane; half width is a multiple of 8.
package tsr_pkg;
    localparam int unsigned TSR_STATE_W = 5;
    localparam int unsigned TSR_HALF_W  = 16;

    typedef enum logic {
        TSR_ADDR_COUNT = 1'b0,
        TSR_ADDR_STATE = 1'b1
    } tsr_addr_e;
endpackage

// File: rtl/tsr_wr_gate.sv
// Module: write permission gate. Turns a bus write into per-byte count
// enables and per-half state enables, and registers the refused-write error.
// Assumes: the low half owns the lower half of the byte lanes; state fields
// start at the first byte of each half.
module tsr_wr_gate
    import tsr_pkg::*;
#(
    parameter int unsigned HALF_W = TSR_HALF_W,
    localparam int unsigned NBYTES = (2 * HALF_W) / 8,
    localparam int unsigned HALF_BYTES = NBYTES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unify,
    input  logic              halt_lo,
    input  logic              halt_hi,
    input  logic              wr,
    input  logic              addr,
    input  logic [NBYTES-1:0] wstrb,
    output logic [NBYTES-1:0] cnt_be,
    output logic [1:0]        st_we,
    output logic              err_q
);
    logic lo_req, hi_req, lo_ok, hi_ok, refuse, sel_cnt, sel_st;

    // Decode which halves are addressed and whether each may be written.
    always_comb begin
        lo_req  = |wstrb[HALF_BYTES-1:0];
        hi_req  = |wstrb[NBYTES-1:HALF_BYTES];
        lo_ok   = halt_lo;
        hi_ok   = unify ? halt_lo : halt_hi;
        refuse  = wr & ((lo_req & ~lo_ok) | (hi_req & ~hi_ok));
        sel_cnt = wr & (tsr_addr_e'(addr) == TSR_ADDR_COUNT);
        sel_st  = wr & (tsr_addr_e'(addr) == TSR_ADDR_STATE);
        st_we[0] = sel_st & wstrb[0] & lo_ok;
        st_we[1] = sel_st & wstrb[HALF_BYTES] & halt_hi & ~unify;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_be
        if (b < HALF_BYTES) begin : g_lo
            assign cnt_be[b] = sel_cnt & wstrb[b] & lo_ok;
        end else begin : g_hi
            assign cnt_be[b] = sel_cnt & wstrb[b] & hi_ok;
        end
    end

    // Register the error response for the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= refuse;
    end

    p_err_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(wr));
    p_running_lo_no_err_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && |wstrb[HALF_BYTES-1:0] && !halt_lo) |=> err_q);
endmodule

// File: rtl/tsr_state_half.sv
// Module: one 5-bit state variable. Software write first, then event load
// or event add (modulo 2^STATE_W); otherwise hold.
// Assumes: sw_we is already gated by halt permission and mode.
module tsr_state_half
    import tsr_pkg::*;
#(
    parameter int unsigned STATE_W = TSR_STATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sw_we,
    input  logic [STATE_W-1:0] sw_val,
    input  logic               ev_vld,
    input  logic               ev_load,
    input  logic [STATE_W-1:0] ev_val,
    output logic [STATE_W-1:0] state_q
);
    logic [STATE_W-1:0] state_d;

    // Pick the next state: software, then event, then hold.
    always_comb begin
        state_d = state_q;
        if (sw_we)                 state_d = sw_val;
        else if (ev_vld && enable) state_d = ev_load ? ev_val : state_q + ev_val;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> state_q == $past(sw_val));
    p_ev_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && ev_vld && enable && ev_load) |=> state_q == $past(ev_val));
    p_ev_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && ev_vld && enable && !ev_load) |=>
        state_q == STATE_W'($past(state_q) + $past(ev_val)));
    p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !sw_we) |=> $stable(state_q));
endmodule

// File: rtl/tsr_counter.sv
// Module: count register. Split mode: two independent HALF_W counters.
// Unified mode: one 2*HALF_W counter run by halt_lo. Permitted byte writes
// take precedence over counting.
// Assumes: byte enables arrive already permission-gated.
module tsr_counter
    import tsr_pkg::*;
#(
    parameter int unsigned HALF_W = TSR_HALF_W,
    localparam int unsigned DATA_W = 2 * HALF_W,
    localparam int unsigned NBYTES = DATA_W / 8,
    localparam int unsigned HALF_BYTES = NBYTES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unify,
    input  logic              halt_lo,
    input  logic              halt_hi,
    input  logic [NBYTES-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_q
);
    logic [DATA_W-1:0] merged, cnt_d;
    logic              wr_lo, wr_hi;

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : cnt_q[b*8 +: 8];
    end

    // Select per mode between written bytes, increment and hold.
    always_comb begin
        wr_lo = |be[HALF_BYTES-1:0];
        wr_hi = |be[NBYTES-1:HALF_BYTES];
        cnt_d = cnt_q;
        if (unify) begin
            if (wr_lo || wr_hi) cnt_d = merged;
            else if (!halt_lo)  cnt_d = cnt_q + DATA_W'(1);
        end else begin
            if (wr_lo)         cnt_d[HALF_W-1:0] = merged[HALF_W-1:0];
            else if (!halt_lo) cnt_d[HALF_W-1:0] = cnt_q[HALF_W-1:0] + HALF_W'(1);
            if (wr_hi)         cnt_d[DATA_W-1:HALF_W] = merged[DATA_W-1:HALF_W];
            else if (!halt_hi) cnt_d[DATA_W-1:HALF_W] = cnt_q[DATA_W-1:HALF_W] + HALF_W'(1);
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_split_lo_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!unify && !halt_lo && !(|be[HALF_BYTES-1:0])) |=>
        cnt_q[HALF_W-1:0] == HALF_W'($past(cnt_q[HALF_W-1:0]) + 1'b1));
    p_split_hi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!unify && halt_hi && !(|be[NBYTES-1:HALF_BYTES])) |=>
        $stable(cnt_q[DATA_W-1:HALF_W]));
    p_unified_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (unify && !halt_lo && !(|be)) |=> cnt_q == DATA_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/tsr_regunit.sv
// Module: top of the timer state/count register unit. Wires the write gate,
// one state variable per half and the counter, and forms the read word.
// Assumes: bus_addr is 0 for the count and 1 for the state register.
module tsr_regunit
    import tsr_pkg::*;
#(
    parameter int unsigned STATE_W = TSR_STATE_W,
    parameter int unsigned HALF_W  = TSR_HALF_W,
    localparam int unsigned DATA_W = 2 * HALF_W,
    localparam int unsigned NBYTES = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unify,
    input  logic               halt_lo,
    input  logic               halt_hi,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [NBYTES-1:0]  bus_wstrb,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic               ev_lo_vld,
    input  logic               ev_lo_load,
    input  logic [STATE_W-1:0] ev_lo_val,
    input  logic               ev_hi_vld,
    input  logic               ev_hi_load,
    input  logic [STATE_W-1:0] ev_hi_val,
    output logic [STATE_W-1:0] state_lo,
    output logic [STATE_W-1:0] state_hi,
    output logic [DATA_W-1:0]  count
);
    localparam logic [DATA_W-1:0] ST_MASK =
        (DATA_W'((1 << STATE_W) - 1) << HALF_W) | DATA_W'((1 << STATE_W) - 1);

    logic [NBYTES-1:0]              cnt_be;
    logic [1:0]                     st_we;
    logic [1:0]                     h_en, h_vld, h_load;
    logic [1:0][STATE_W-1:0]        h_wval, h_ev, h_q;
    logic [DATA_W-1:0]              state_word;

    tsr_wr_gate #(.HALF_W(HALF_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .unify(unify), .halt_lo(halt_lo),
        .halt_hi(halt_hi), .wr(bus_wr), .addr(bus_addr), .wstrb(bus_wstrb),
        .cnt_be(cnt_be), .st_we(st_we), .err_q(bus_err)
    );

    // Gather per-half event and write inputs into indexable vectors.
    always_comb begin
        h_en   = {~unify, 1'b1};
        h_vld  = {ev_hi_vld, ev_lo_vld};
        h_load = {ev_hi_load, ev_lo_load};
        h_ev   = {ev_hi_val, ev_lo_val};
        h_wval = {bus_wdata[HALF_W +: STATE_W], bus_wdata[STATE_W-1:0]};
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        tsr_state_half #(.STATE_W(STATE_W)) u_state (
            .clk(clk), .rst_n(rst_n), .enable(h_en[h]), .sw_we(st_we[h]),
            .sw_val(h_wval[h]), .ev_vld(h_vld[h]), .ev_load(h_load[h]),
            .ev_val(h_ev[h]), .state_q(h_q[h])
        );
    end

    tsr_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .unify(unify), .halt_lo(halt_lo),
        .halt_hi(halt_hi), .be(cnt_be), .wdata(bus_wdata), .cnt_q(count)
    );

    // Form the state read word and select the read data by address.
    always_comb begin
        state_lo   = h_q[0];
        state_hi   = h_q[1];
        state_word = '0;
        state_word[STATE_W-1:0] = h_q[0];
        if (!unify) state_word[HALF_W +: STATE_W] = h_q[1];
        bus_rdata = (tsr_addr_e'(bus_addr) == TSR_ADDR_STATE) ? state_word : count;
    end

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 1'b1) |-> (bus_rdata & ~ST_MASK) == '0);
    p_unified_hi_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unify && bus_addr == 1'b1) |-> bus_rdata[HALF_W +: STATE_W] == '0);
    p_running_lo_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_lo && !ev_lo_vld) |=> $stable(state_lo));
endmodule

// File: tb/tsr_regunit_bench.sv
// Bench: sweeps modes, halts, strobes and event values against a bench model.
module tsr_regunit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unify = 1'b0, halt_lo = 1'b1, halt_hi = 1'b1;
    logic        bus_wr = 1'b0, bus_addr = 1'b0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ev_lo_vld = 1'b0, ev_lo_load = 1'b0, ev_hi_vld = 1'b0, ev_hi_load = 1'b0;
    logic [4:0]  ev_lo_val = '0, ev_hi_val = '0;
    logic [4:0]  state_lo, state_hi;
    logic [31:0] count;

    int unsigned n_checks = 0, n_errors = 0;
    logic [4:0]  m_slo = '0, m_shi = '0;
    logic [31:0] m_cnt = '0;
    logic        m_err = 1'b0;

    always #5 clk = ~clk;

    tsr_regunit u_tsr_regunit (
        .clk(clk), .rst_n(rst_n), .unify(unify), .halt_lo(halt_lo), .halt_hi(halt_hi),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .ev_lo_vld(ev_lo_vld), .ev_lo_load(ev_lo_load), .ev_lo_val(ev_lo_val),
        .ev_hi_vld(ev_hi_vld), .ev_hi_load(ev_hi_load), .ev_hi_val(ev_hi_val),
        .state_lo(state_lo), .state_hi(state_hi), .count(count)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        logic lo_ok, hi_ok, lo_req, hi_req;
        logic [31:0] merged;
        logic any_lo, any_hi;
        lo_req = |bus_wstrb[1:0];
        hi_req = |bus_wstrb[3:2];
        lo_ok  = halt_lo;
        hi_ok  = unify ? halt_lo : halt_hi;
        m_err  = bus_wr && ((lo_req && !lo_ok) || (hi_req && !hi_ok));
        if (bus_wr && bus_addr && bus_wstrb[0] && lo_ok) m_slo = bus_wdata[4:0];
        else if (ev_lo_vld) m_slo = ev_lo_load ? ev_lo_val : 5'(m_slo + ev_lo_val);
        if (!unify) begin
            if (bus_wr && bus_addr && bus_wstrb[2] && halt_hi) m_shi = bus_wdata[20:16];
            else if (ev_hi_vld) m_shi = ev_hi_load ? ev_hi_val : 5'(m_shi + ev_hi_val);
        end
        merged = m_cnt;
        any_lo = 1'b0;
        any_hi = 1'b0;
        for (int b = 0; b < 4; b++) begin
            if (bus_wr && !bus_addr && bus_wstrb[b] && (b < 2 ? lo_ok : hi_ok)) begin
                merged[b*8 +: 8] = bus_wdata[b*8 +: 8];
                if (b < 2) any_lo = 1'b1; else any_hi = 1'b1;
            end
        end
        if (unify) begin
            if (any_lo || any_hi) m_cnt = merged;
            else if (!halt_lo)    m_cnt = m_cnt + 32'd1;
        end else begin
            if (any_lo)        m_cnt[15:0] = merged[15:0];
            else if (!halt_lo) m_cnt[15:0] = m_cnt[15:0] + 16'd1;
            if (any_hi)        m_cnt[31:16] = merged[31:16];
            else if (!halt_hi) m_cnt[31:16] = m_cnt[31:16] + 16'd1;
        end
    endtask

    task automatic check_all(input string req);
        logic a_save;
        chk(req, "state_lo", 32'(state_lo), 32'(m_slo));
        chk(req, "state_hi", 32'(state_hi), 32'(m_shi));
        chk(req, "count", count, m_cnt);
        chk(req, "bus_err", 32'(bus_err), 32'(m_err));
        a_save = bus_addr;
        bus_addr = 1'b1;
        #1;
        chk("R2", "state read", bus_rdata, {11'd0, unify ? 5'd0 : m_shi, 11'd0, m_slo});
        bus_addr = 1'b0;
        #1;
        chk("R12", "count read", bus_rdata, m_cnt);
        bus_addr = a_save;
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all(req);
    endtask

    task automatic quiet();
        bus_wr = 1'b0; bus_wstrb = '0;
        ev_lo_vld = 1'b0; ev_hi_vld = 1'b0;
    endtask

    task automatic write(input logic a, input logic [3:0] s, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wstrb = s; bus_wdata = d;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R3 R4 R5: state writes over every mode, halt pair and strobe pattern.
        for (int u = 0; u < 2; u++)
            for (int hl = 0; hl < 2; hl++)
                for (int hh = 0; hh < 2; hh++)
                    for (int s = 0; s < 16; s++) begin
                        unify = 1'(u); halt_lo = 1'(hl); halt_hi = 1'(hh);
                        write(1'b1, 4'(s), 32'hFFE0_FFE0 | {11'd0, 5'(s + 7), 11'd0, 5'(s * 3 + 1)});
                        tick("R3 R4 R5");
                        quiet();
                        tick("R4");
                    end

        // R11 R9 R10: count writes over the same space; running halves count.
        for (int u = 0; u < 2; u++)
            for (int hl = 0; hl < 2; hl++)
                for (int hh = 0; hh < 2; hh++)
                    for (int s = 0; s < 16; s++) begin
                        unify = 1'(u); halt_lo = 1'(hl); halt_hi = 1'(hh);
                        write(1'b0, 4'(s), 32'h1357_9BDF ^ {4{8'(s * 17)}});
                        tick("R11 R4");
                        quiet();
                        tick("R9 R10");
                    end

        // R6 R7: every state and event value, load and add, both halves.
        unify = 1'b0; halt_lo = 1'b1; halt_hi = 1'b1;
        for (int st = 0; st < 32; st++)
            for (int v = 0; v < 32; v++)
                for (int l = 0; l < 2; l++) begin
                    write(1'b1, 4'b0101, {11'd0, 5'(st) ^ 5'd31, 11'd0, 5'(st)});
                    tick("R3");
                    quiet();
                    ev_lo_vld = 1'b1; ev_lo_load = 1'(l); ev_lo_val = 5'(v);
                    ev_hi_vld = 1'b1; ev_hi_load = ~1'(l); ev_hi_val = 5'(v) ^ 5'h0A;
                    tick("R6 R7");
                    quiet();
                end

        // R5: events in unified mode touch only the low state.
        unify = 1'b1; halt_lo = 1'b0;
        for (int v = 1; v < 8; v++) begin
            ev_lo_vld = 1'b1; ev_lo_load = 1'(v & 1); ev_lo_val = 5'(v * 5);
            ev_hi_vld = 1'b1; ev_hi_load = 1'b1; ev_hi_val = 5'(v);
            tick("R5 R7");
        end
        quiet();

        // R8: software write and event on the same half; refused write lets event act.
        unify = 1'b0;
        for (int v = 0; v < 6; v++) begin
            halt_lo = 1'b1; halt_hi = 1'(v & 1);
            write(1'b1, 4'b0101, {11'd0, 5'(v + 20), 11'd0, 5'(v + 9)});
            ev_lo_vld = 1'b1; ev_lo_load = 1'(v & 1); ev_lo_val = 5'(v * 7);
            ev_hi_vld = 1'b1; ev_hi_load = 1'b0;      ev_hi_val = 5'(v + 3);
            tick("R8 R4");
            quiet();
            tick("R4");
        end

        // R9: split halves wrap independently.
        unify = 1'b0; halt_lo = 1'b1; halt_hi = 1'b1;
        write(1'b0, 4'b1111, 32'hFFFD_FFFE);
        tick("R11");
        quiet();
        halt_lo = 1'b0;
        for (int i = 0; i < 4; i++) tick("R9");
        halt_hi = 1'b0;
        for (int i = 0; i < 5; i++) tick("R9");

        // R10: unified carry across the half boundary and full wrap.
        unify = 1'b1; halt_lo = 1'b1;
        write(1'b0, 4'b1111, 32'h0000_FFFE);
        tick("R11");
        quiet();
        halt_lo = 1'b0; halt_hi = 1'b1;
        for (int i = 0; i < 4; i++) tick("R10");
        halt_lo = 1'b1;
        write(1'b0, 4'b1111, 32'hFFFF_FFFE);
        tick("R11");
        quiet();
        halt_lo = 1'b0;
        for (int i = 0; i < 4; i++) tick("R10");

        // R1: reset mid-run returns everything to zero.
        rst_n = 1'b0;
        @(posedge clk);
        m_slo = '0; m_shi = '0; m_cnt = '0; m_err = 1'b0;
        @(negedge clk);
        halt_lo = 1'b1;
        rst_n = 1'b1;
        check_all("R1");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule